// File: doc/BRIEF.md
# Reset Warm-up Sequencer

This block turns three reset sources into one chip reset: an active-low power-on reset, an active-low external reset pin and an active-high internal reset request. Any one of them forces the CPU and peripheral reset low at once, without waiting for a clock edge. Each source release passes through a two-stage synchronizer, so it takes effect only on clock edges. While reset is held, the warm-up counter, the trim loader and the sequencing state machine stay cleared.

Once reset is released, a warm-up counter runs on the high-frequency clock up to a programmable length. Over the same window, a loader reads trimming words from non-volatile memory. It uses a simple request/acknowledge read port and writes each word to a trim register through a one-cycle strobe. The loader then reads the two reset-vector bytes: the byte at 0xFFFE is the low byte and the byte at 0xFFFF is the high byte. The CPU is released only when both the counter and the load have finished.

A reset from any source during warm-up clears everything, and the whole sequence starts again from its first step.

Top module: `rstwu_seq`

## Requirements
- R1: Driving `por_n` low, driving `ext_rst_n` low or driving `int_rst` high sets `cpu_rst_n` low immediately, with no clock edge needed.
- R2: While any reset source is active, `cpu_rst_n` is 0, `nvm_rd` is 0 and `trim_we` is 0.
- R3: Release is synchronized through two clock edges. Count clock edges from the release, with the first edge as edge 1. When the trim load finishes first, `cpu_rst_n` rises right after edge `4 + wu_len`.
- R4: The loader reads `N_TRIM` words at addresses `TRIM_BASE + k`, for k ascending from 0. Each read produces one `trim_we` pulse, with `trim_idx = k` and `trim_data` equal to the word read.
- R5: After the trim words, the loader reads address 0xFFFE and then address 0xFFFF. `rst_vector` is `{byte@0xFFFF, byte@0xFFFE}`, taking bits [7:0] of each read, and it is valid while `cpu_rst_n` is 1.
- R6: If the load is still running when the counter expires, the block stays in warm-up. `cpu_rst_n` then rises one edge after the edge that captures the last vector byte.
- R7: A reset asserted during warm-up restarts both the counter and the loader from the beginning. The timing and the trim writes after the next release are the same as after a fresh reset.
- R8: Once `cpu_rst_n` is 1, it stays 1 until a reset source becomes active.
- R9: `nvm_rd` stays high with a stable `nvm_addr` until the cycle in which `nvm_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-frequency clock |
| por_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| int_rst | input | 1 | Internal reset request, active high |
| wu_len | input | CNT_W | Warm-up length in clock cycles |
| nvm_rd | output | 1 | NVM read request |
| nvm_addr | output | 16 | NVM read address |
| nvm_rdata | input | DW | NVM read data, valid with `nvm_ack` |
| nvm_ack | input | 1 | NVM read acknowledge |
| trim_we | output | 1 | Trim register write strobe |
| trim_idx | output | IDX_W | Index of the trim register being written |
| trim_data | output | DW | Trim word being written |
| cpu_rst_n | output | 1 | CPU and peripheral reset, active low |
| rst_vector | output | 16 | Reset vector handed to the CPU |

## Verification
The embedded properties check these rules on every cycle:
- the read request holds its address until it is acknowledged;
- trim strobes carry only legal indices;
- the NVM port and the strobe stay quiet in the reset state;
- the counter steps by one during warm-up;
- the CPU leaves reset only after both the load and the counter are complete;
- once in RUN, the block stays there.

Only the bench scenarios can show the exact release cycle for each mix of warm-up length and NVM latency, the values that reach the trim registers and the vector, the asynchronous effect of each source, and the full restart after a reset in the middle of warm-up.

// File: rtl/rstwu_pkg.sv
package rstwu_pkg;

  typedef enum logic [1:0] {
    ST_RESET   = 2'd0,
    ST_WU_LOAD = 2'd1,
    ST_WU_WAIT = 2'd2,
    ST_RUN     = 2'd3
  } seq_state_e;

  localparam logic [15:0] VEC_LO_ADDR = 16'hFFFE;
  localparam logic [15:0] VEC_HI_ADDR = 16'hFFFF;

  // Address of load item: trims first, then vector low, then vector high.
  function automatic logic [15:0] item_addr(input int unsigned item,
                                            input int unsigned n_trim,
                                            input logic [15:0] base);
    if (item < n_trim) return base + 16'(item);
    else if (item == n_trim) return VEC_LO_ADDR;
    else return VEC_HI_ADDR;
  endfunction

  function automatic logic wu_reached(input logic [31:0] cnt, input logic [31:0] len);
    return cnt >= len;
  endfunction

  function automatic logic [15:0] join_vector(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/rstwu_sync.sv
module rstwu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/rstwu_wu_timer.sv
module rstwu_wu_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [CNT_W-1:0] wu_len,
  output logic             expired
);
  import rstwu_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             at_max;

  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!count_en)          cnt <= '0;
    else if (!at_max)            cnt <= cnt + 1'b1;
  end

  assign expired = wu_reached(32'(cnt), 32'(wu_len));

  // R3: warm-up counter advances by exactly one each enabled cycle
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !at_max) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rstwu_loader.sv
module rstwu_loader #(
  parameter int          N_TRIM    = 4,
  parameter int          DW        = 8,
  parameter logic [15:0] TRIM_BASE = 16'h0F40,
  parameter int          IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             nvm_rd,
  output logic [15:0]      nvm_addr,
  input  logic [DW-1:0]    nvm_rdata,
  input  logic             nvm_ack,
  output logic             trim_we,
  output logic [IDX_W-1:0] trim_idx,
  output logic [DW-1:0]    trim_data,
  output logic [15:0]      vector,
  output logic             done
);
  import rstwu_pkg::*;

  localparam int N_ITEMS = N_TRIM + 2;
  localparam int ITEM_W  = $clog2(N_ITEMS + 1);
  localparam logic [ITEM_W-1:0] LAST_TRIM = ITEM_W'(N_TRIM);
  localparam logic [ITEM_W-1:0] ITEM_LO   = ITEM_W'(N_TRIM);
  localparam logic [ITEM_W-1:0] ITEM_HI   = ITEM_W'(N_TRIM + 1);
  localparam logic [ITEM_W-1:0] ITEM_END  = ITEM_W'(N_ITEMS);

  logic [ITEM_W-1:0] item;
  logic [7:0]        vec_lo, vec_hi;
  logic              capture;

  assign done     = (item == ITEM_END);
  assign nvm_rd   = start && !done;
  assign nvm_addr = item_addr(32'(item), N_TRIM, TRIM_BASE);
  assign capture  = nvm_rd && nvm_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      item      <= '0;
      trim_we   <= 1'b0;
      trim_idx  <= '0;
      trim_data <= '0;
      vec_lo    <= '0;
      vec_hi    <= '0;
    end else begin
      trim_we <= capture && (item < LAST_TRIM);
      if (capture) begin
        item <= item + 1'b1;
        if (item < LAST_TRIM) begin
          trim_idx  <= IDX_W'(item);
          trim_data <= nvm_rdata;
        end
        if (item == ITEM_LO) vec_lo <= nvm_rdata[7:0];
        if (item == ITEM_HI) vec_hi <= nvm_rdata[7:0];
      end
    end
  end

  assign vector = join_vector(vec_lo, vec_hi);

  // R9: a pending read keeps its request and address until acknowledged
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_rd && !nvm_ack && start) |=> (nvm_rd && $stable(nvm_addr)));

  // R4: every trim strobe names an existing trim register
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    trim_we |-> (32'(trim_idx) < N_TRIM));

endmodule

// File: rtl/rstwu_seq.sv
module rstwu_seq #(
  parameter int          N_TRIM    = 4,
  parameter int          DW        = 8,
  parameter int          CNT_W     = 16,
  parameter int          SYNC_STG  = 2,
  parameter logic [15:0] TRIM_BASE = 16'h0F40,
  parameter int          IDX_W     = (N_TRIM > 1) ? $clog2(N_TRIM) : 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             int_rst,
  input  logic [CNT_W-1:0] wu_len,
  output logic             nvm_rd,
  output logic [15:0]      nvm_addr,
  input  logic [DW-1:0]    nvm_rdata,
  input  logic             nvm_ack,
  output logic             trim_we,
  output logic [IDX_W-1:0] trim_idx,
  output logic [DW-1:0]    trim_data,
  output logic             cpu_rst_n,
  output logic [15:0]      rst_vector
);
  import rstwu_pkg::*;

  logic       arst_n;
  logic       rst_sync_n;
  seq_state_e state, state_nx;
  logic       load_start;
  logic       load_done;
  logic       wu_expired;
  logic       wu_count_en;
  logic       in_run;

  // Any source asserts reset asynchronously.
  assign arst_n = por_n & ext_rst_n & ~int_rst;

  rstwu_sync #(.STAGES(SYNC_STG)) sync_i (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (rst_sync_n)
  );

  assign wu_count_en = (state == ST_WU_LOAD) || (state == ST_WU_WAIT);
  assign load_start  = (state != ST_RESET);
  assign in_run      = (state == ST_RUN);

  rstwu_wu_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .count_en (wu_count_en),
    .wu_len   (wu_len),
    .expired  (wu_expired)
  );

  rstwu_loader #(
    .N_TRIM    (N_TRIM),
    .DW        (DW),
    .TRIM_BASE (TRIM_BASE),
    .IDX_W     (IDX_W)
  ) loader_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (load_start),
    .nvm_rd    (nvm_rd),
    .nvm_addr  (nvm_addr),
    .nvm_rdata (nvm_rdata),
    .nvm_ack   (nvm_ack),
    .trim_we   (trim_we),
    .trim_idx  (trim_idx),
    .trim_data (trim_data),
    .vector    (rst_vector),
    .done      (load_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RESET:   state_nx = ST_WU_LOAD;
      ST_WU_LOAD: if (load_done) state_nx = wu_expired ? ST_RUN : ST_WU_WAIT;
      ST_WU_WAIT: if (wu_expired) state_nx = ST_RUN;
      ST_RUN:     state_nx = ST_RUN;
      default:    state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state <= ST_RESET;
    else             state <= state_nx;
  end

  assign cpu_rst_n = in_run;

  // R8: run state is left only through reset
  a_r8_run_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_run |=> in_run);

  // R6: release requires both a finished load and an expired counter
  a_r6_release_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(in_run) |-> ($past(load_done) && $past(wu_expired)));

  // R2: nothing reaches NVM or trim registers from the reset state
  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_RESET) |-> (!nvm_rd && !trim_we && !cpu_rst_n));

endmodule

// File: tb/rstwu_seq_tb_top.sv
module rstwu_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          N_TRIM     = 4;
  localparam int          DW         = 8;
  localparam int          CNT_W      = 16;
  localparam int          IDX_W      = 2;
  localparam int          N_ITEMS    = N_TRIM + 2;
  localparam logic [15:0] TRIM_BASE  = 16'h0F40;

  // Stimulus table: warm-up length, NVM latency, source (0 por, 1 ext, 2 int)
  localparam int N_VEC = 5;
  localparam int TBL_WU [N_VEC]  = '{10, 0, 40, 3, 60};
  localparam int TBL_LAT[N_VEC]  = '{0, 3, 0, 1, 2};
  localparam int TBL_SRC[N_VEC]  = '{0, 1, 2, 0, 1};

  logic             clk = 1'b0;
  logic             por_n = 1'b0;
  logic             ext_rst_n = 1'b1;
  logic             int_rst = 1'b0;
  logic [CNT_W-1:0] wu_len = '0;
  logic             nvm_rd;
  logic [15:0]      nvm_addr;
  logic [DW-1:0]    nvm_rdata = '0;
  logic             nvm_ack = 1'b0;
  logic             trim_we;
  logic [IDX_W-1:0] trim_idx;
  logic [DW-1:0]    trim_data;
  logic             cpu_rst_n;
  logic [15:0]      rst_vector;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int wcnt = 0;
  int n_log = 0;
  int log_idx[256];
  int log_dat[256];

  rstwu_seq #(.N_TRIM(N_TRIM), .DW(DW), .CNT_W(CNT_W), .TRIM_BASE(TRIM_BASE)) dut_i (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .int_rst(int_rst),
    .wu_len(wu_len), .nvm_rd(nvm_rd), .nvm_addr(nvm_addr), .nvm_rdata(nvm_rdata),
    .nvm_ack(nvm_ack), .trim_we(trim_we), .trim_idx(trim_idx), .trim_data(trim_data),
    .cpu_rst_n(cpu_rst_n), .rst_vector(rst_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  // Release edge: warm-up bound vs. last vector capture plus one.
  function automatic int exp_release(input int wu, input int l);
    int last_cap;
    last_cap = 4 + l + (N_ITEMS - 1) * (l + 2);
    return ((4 + wu) > (last_cap + 1)) ? (4 + wu) : (last_cap + 1);
  endfunction

  // NVM responder and trim monitor, acting on falling edges.
  always @(negedge clk) begin
    if (nvm_ack) begin
      nvm_ack <= 1'b0;
      wcnt    <= 0;
    end else if (nvm_rd) begin
      if (wcnt == lat) begin
        nvm_ack   <= 1'b1;
        nvm_rdata <= mem_byte(nvm_addr);
      end else wcnt <= wcnt + 1;
    end else wcnt <= 0;
    if (trim_we && n_log < 256) begin
      log_idx[n_log] <= int'(trim_idx);
      log_dat[n_log] <= int'(trim_data);
      n_log <= n_log + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int src, input bit active);
    case (src)
      0: por_n = !active;
      1: ext_rst_n = !active;
      default: int_rst = active;
    endcase
  endtask

  // Measure clock edges from release to cpu_rst_n high, then check loads.
  task automatic release_and_check(input int src, input int wu, input int l, input string tag);
    int t;
    int base;
    int exp_t;
    @(negedge clk);
    base = n_log;
    set_src(src, 1'b0);
    t = 0;
    while (!cpu_rst_n && t < 4000) begin
      @(posedge clk);
      t++;
      @(negedge clk);
    end
    #1;
    exp_t = exp_release(wu, l);
    check(t == exp_t, tag, t, exp_t);
    check((n_log - base) == N_TRIM, "R4 trim count", n_log - base, N_TRIM);
    for (int k = 0; k < N_TRIM; k++) begin
      check(log_idx[base + k] == k, "R4 trim index", log_idx[base + k], k);
      check(log_dat[base + k] == int'(mem_byte(TRIM_BASE + 16'(k))), "R4 trim data",
            log_dat[base + k], int'(mem_byte(TRIM_BASE + 16'(k))));
    end
    check(rst_vector == {mem_byte(16'hFFFF), mem_byte(16'hFFFE)}, "R5 vector",
          int'(rst_vector), int'({mem_byte(16'hFFFF), mem_byte(16'hFFFE)}));
    repeat (10) @(negedge clk);
    check(cpu_rst_n == 1'b1, "R8 stays released", int'(cpu_rst_n), 1);
  endtask

  task automatic run_case(input int wu, input int l, input int src);
    wu_len = CNT_W'(wu);
    lat = l;
    @(negedge clk);
    set_src(src, 1'b1);
    #1;
    check(cpu_rst_n == 1'b0, "R1 async assert", int'(cpu_rst_n), 0);
    repeat (3) @(negedge clk);
    check(cpu_rst_n == 1'b0 && !nvm_rd && !trim_we, "R2 held in reset",
          int'({cpu_rst_n, nvm_rd, trim_we}), 0);
    if ((4 + wu) >= exp_release(wu, l))
      release_and_check(src, wu, l, "R3 release edge");
    else
      release_and_check(src, wu, l, "R6 release after load");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Reset state (R2)
    #1;
    check(cpu_rst_n == 1'b0, "R2 reset state cpu", int'(cpu_rst_n), 0);
    check(nvm_rd == 1'b0, "R2 reset state nvm", int'(nvm_rd), 0);
    repeat (4) @(negedge clk);
    check(!nvm_rd && !trim_we, "R2 no activity in reset", int'({nvm_rd, trim_we}), 0);
    wu_len = CNT_W'(5);
    release_and_check(0, 5, 0, "R6 first power-up");

    for (int v = 0; v < N_VEC; v++) run_case(TBL_WU[v], TBL_LAT[v], TBL_SRC[v]);

    // R7: external reset in the middle of warm-up restarts everything
    wu_len = CNT_W'(20);
    lat = 0;
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(cpu_rst_n == 1'b0, "R7 still warming", int'(cpu_rst_n), 0);
    ext_rst_n = 1'b0;
    #1;
    check(cpu_rst_n == 1'b0, "R1 R7 reassert mid warm-up", int'(cpu_rst_n), 0);
    repeat (2) @(negedge clk);
    check(!nvm_rd, "R7 loader stopped", int'(nvm_rd), 0);
    release_and_check(1, 20, 0, "R7 restart timing");

    // Internal request in run: immediate effect then normal sequence
    wu_len = CNT_W'(7);
    @(negedge clk);
    int_rst = 1'b1;
    #1;
    check(cpu_rst_n == 1'b0, "R1 internal request", int'(cpu_rst_n), 0);
    @(negedge clk);
    release_and_check(2, 7, 0, "R6 short warm-up");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule